// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block links two 18-bit buses, an A side and a B side, through two independent one-way paths: A toward B and B toward A. Each path keeps a storage word, and one set of controls (a latch enable, a capture strobe and an active-low output enable) chooses how that word moves. With the latch enable high the path follows its source every cycle. With the latch enable low and no strobe, the path holds its value. A one-cycle capture strobe loads the word on that edge. The design is synchronous to one system clock, so the capture strobe stands in for a per-direction clock edge.

The bus is split into two 9-bit halves. In split operation each half takes its controls from its own index. In wide operation the index-0 controls govern both halves as a single 18-bit word. Tri-state is not modelled with high-impedance values. Each half of each output bus has an output-enable flag that a pad ring turns into a tri-state driver. A test-mode input gives the outputs and enables to an external test block and freezes both storage words.

Top module: `bus_xcvr18`

## Requirements
- R1: While `rst` is sampled high, both storage words clear to zero. On the cycle after `rst` is sampled high, `a_out`, `b_out`, `a_oe` and `b_oe` all read zero.
- R2: With the latch enable of a half high (and not in test mode), that half's destination output equals its source input sampled at the previous rising clock edge. The path is transparent with one cycle of latency.
- R3: With the latch enable and capture strobe of a half both low, that half's output holds its stored value, and changes on the source input are ignored.
- R4: With the latch enable low and the capture strobe high for one cycle, the half stores the source value from that edge and shows it one cycle later.
- R5: The output-enable bit of a half is the inverse of its active-low enable input from the previous cycle. A value of 0 on `ab_oe_n`/`ba_oe_n` gives 1 on `b_oe`/`a_oe`.
- R6: The B-to-A path uses only `ba_oe_n`, `ba_le`, `ba_cap` and `b_in`, and the A-to-B path uses only the `ab_*` controls and `a_in`. Activity on one path leaves the other path's output unchanged.
- R7: With `wide_mode` low, half 0 is bits [8:0] and uses control bit [0]. Half 1 is bits [17:9] and uses control bit [1].
- R8: With `wide_mode` high, control bit [0] of each control vector governs both halves, and bit [1] is ignored.
- R9: With `test_mode` high, each output bus and enable equals the matching `tst_*` input from the previous cycle.
- R10: In test mode neither storage word changes. After `test_mode` returns low with the latch enable and strobe low, the outputs show the value stored before test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | Hands the outputs to the test inputs and freezes storage |
| wide_mode | input | 1 | 1: index-0 controls drive both halves |
| a_in | input | 18 | A-side bus input |
| a_out | output | 18 | A-side bus output (B-to-A path) |
| a_oe | output | 2 | Per-half drive enable for A side, active high |
| b_in | input | 18 | B-side bus input |
| b_out | output | 18 | B-side bus output (A-to-B path) |
| b_oe | output | 2 | Per-half drive enable for B side, active high |
| ab_oe_n | input | 2 | A-to-B output enable per half, active low |
| ab_le | input | 2 | A-to-B latch enable per half |
| ab_cap | input | 2 | A-to-B capture strobe per half |
| ba_oe_n | input | 2 | B-to-A output enable per half, active low |
| ba_le | input | 2 | B-to-A latch enable per half |
| ba_cap | input | 2 | B-to-A capture strobe per half |
| tst_a_out | input | 18 | Test value for `a_out` |
| tst_a_oe | input | 2 | Test value for `a_oe` |
| tst_b_out | input | 18 | Test value for `b_out` |
| tst_b_oe | input | 2 | Test value for `b_oe` |

## Verification
Every result of this block, whether transparent data, captured data, held data, enable flags or test overrides, appears one clock after the edge that samples its stimulus. No path has a combinational route from input to output. The bench applies each vector half a period before a rising edge and compares the outputs half a period after that edge, which is exactly one register stage. Hold and freeze cases are checked on the cycle after the source input has changed, so a path that wrongly passed data through would show the new value there.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Controls for one half of one direction
  typedef struct packed {
    logic oe_n;  // active-low drive enable
    logic le;    // follow source every cycle
    logic cap;   // load source on this edge
  } half_ctrl_t;
endpackage

// File: rtl/xcvr_ctrl_sel.sv
module xcvr_ctrl_sel
  import xcvr_pkg::*;
#(
  parameter int HALVES = 2
) (
  input  logic                           wide_mode,
  input  logic        [HALVES-1:0]       oe_n,
  input  logic        [HALVES-1:0]       le,
  input  logic        [HALVES-1:0]       cap,
  output half_ctrl_t  [HALVES-1:0]       ctrl
);
  // Wide operation: index 0 steers every half
  for (genvar h = 0; h < HALVES; h++) begin : g_sel
    always_comb begin
      if (wide_mode) begin
        ctrl[h].oe_n = oe_n[0];
        ctrl[h].le   = le[0];
        ctrl[h].cap  = cap[0];
      end else begin
        ctrl[h].oe_n = oe_n[h];
        ctrl[h].le   = le[h];
        ctrl[h].cap  = cap[h];
      end
    end
  end
endmodule

// File: rtl/xcvr_half_path.sv
module xcvr_half_path
  import xcvr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_mode,
  input  half_ctrl_t   ctrl,
  input  logic [W-1:0] din,
  input  logic [W-1:0] tst_d,
  input  logic         tst_oe,
  output logic [W-1:0] dout,
  output logic         oe
);
  logic [W-1:0] store_q;
  logic [W-1:0] store_d;

  // Latch-or-capture storage; frozen while test logic owns the pins
  always_comb begin
    store_d = store_q;
    if (!test_mode && (ctrl.le || ctrl.cap))
      store_d = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      dout    <= '0;
      oe      <= 1'b0;
    end else begin
      store_q <= store_d;
      dout    <= test_mode ? tst_d  : store_d;
      oe      <= test_mode ? tst_oe : ~ctrl.oe_n;
    end
  end
endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
  import xcvr_pkg::*;
#(
  parameter int HALF_W = 9,
  parameter int HALVES = 2,
  localparam int BUS_W = HALF_W * HALVES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_mode,
  input  logic              wide_mode,
  input  logic [HALVES-1:0] oe_n,
  input  logic [HALVES-1:0] le,
  input  logic [HALVES-1:0] cap,
  input  logic [BUS_W-1:0]  din,
  input  logic [BUS_W-1:0]  tst_d,
  input  logic [HALVES-1:0] tst_oe,
  output logic [BUS_W-1:0]  dout,
  output logic [HALVES-1:0] oe
);
  half_ctrl_t [HALVES-1:0] ctrl;

  xcvr_ctrl_sel #(.HALVES(HALVES)) i_sel (
    .wide_mode (wide_mode),
    .oe_n      (oe_n),
    .le        (le),
    .cap       (cap),
    .ctrl      (ctrl)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    xcvr_half_path #(.W(HALF_W)) i_path (
      .clk       (clk),
      .rst       (rst),
      .test_mode (test_mode),
      .ctrl      (ctrl[h]),
      .din       (din[h*HALF_W +: HALF_W]),
      .tst_d     (tst_d[h*HALF_W +: HALF_W]),
      .tst_oe    (tst_oe[h]),
      .dout      (dout[h*HALF_W +: HALF_W]),
      .oe        (oe[h])
    );
  end
endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18 #(
  parameter int HALF_W = 9,
  parameter int HALVES = 2,
  localparam int BUS_W = HALF_W * HALVES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_mode,
  input  logic              wide_mode,
  input  logic [BUS_W-1:0]  a_in,
  output logic [BUS_W-1:0]  a_out,
  output logic [HALVES-1:0] a_oe,
  input  logic [BUS_W-1:0]  b_in,
  output logic [BUS_W-1:0]  b_out,
  output logic [HALVES-1:0] b_oe,
  input  logic [HALVES-1:0] ab_oe_n,
  input  logic [HALVES-1:0] ab_le,
  input  logic [HALVES-1:0] ab_cap,
  input  logic [HALVES-1:0] ba_oe_n,
  input  logic [HALVES-1:0] ba_le,
  input  logic [HALVES-1:0] ba_cap,
  input  logic [BUS_W-1:0]  tst_a_out,
  input  logic [HALVES-1:0] tst_a_oe,
  input  logic [BUS_W-1:0]  tst_b_out,
  input  logic [HALVES-1:0] tst_b_oe
);
  // A toward B
  xcvr_dir #(.HALF_W(HALF_W), .HALVES(HALVES)) i_ab (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .wide_mode (wide_mode),
    .oe_n      (ab_oe_n),
    .le        (ab_le),
    .cap       (ab_cap),
    .din       (a_in),
    .tst_d     (tst_b_out),
    .tst_oe    (tst_b_oe),
    .dout      (b_out),
    .oe        (b_oe)
  );

  // B toward A
  xcvr_dir #(.HALF_W(HALF_W), .HALVES(HALVES)) i_ba (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .wide_mode (wide_mode),
    .oe_n      (ba_oe_n),
    .le        (ba_le),
    .cap       (ba_cap),
    .din       (b_in),
    .tst_d     (tst_a_out),
    .tst_oe    (tst_a_oe),
    .dout      (a_out),
    .oe        (a_oe)
  );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int HALF_W = 9,
  parameter int HALVES = 2,
  localparam int BUS_W = HALF_W * HALVES
) (
  input logic              clk,
  input logic              rst,
  input logic              test_mode,
  input logic              wide_mode,
  input logic [BUS_W-1:0]  a_out,
  input logic [HALVES-1:0] a_oe,
  input logic [BUS_W-1:0]  b_out,
  input logic [HALVES-1:0] b_oe,
  input logic [HALVES-1:0] ab_oe_n,
  input logic [HALVES-1:0] ab_le,
  input logic [HALVES-1:0] ab_cap,
  input logic [HALVES-1:0] ba_oe_n,
  input logic [BUS_W-1:0]  tst_a_out,
  input logic [BUS_W-1:0]  tst_b_out
);
  // R1: reset clears every output one cycle later
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (a_out == '0 && b_out == '0 && a_oe == '0 && b_oe == '0));

  // R5: enables follow the inverted active-low inputs in split mode
  a_r5_oe_split: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && !wide_mode) |=> (b_oe == ~$past(ab_oe_n) && a_oe == ~$past(ba_oe_n)));

  // R8: wide mode takes index 0 for every half
  a_r8_oe_wide: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && wide_mode) |=> (b_oe == {HALVES{~$past(ab_oe_n[0])}}));

  // R9: test mode passes the test values through one register
  a_r9_test_drive: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> (b_out == $past(tst_b_out) && a_out == $past(tst_a_out)));

  // R3: half 0 of A-to-B holds without latch enable or strobe
  a_r3_hold_half0: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && !$past(test_mode) && !wide_mode && !ab_le[0] && !ab_cap[0])
      |=> $stable(b_out[HALF_W-1:0]));
endmodule

bind bus_xcvr18 xcvr_checker #(.HALF_W(HALF_W), .HALVES(HALVES)) i_chk (.*);

// File: tb/test_bus_xcvr18.sv
`timescale 1ns/1ps
module test_bus_xcvr18;
  logic        clk = 1'b0;
  logic        rst;
  logic        test_mode, wide_mode;
  logic [17:0] a_in, a_out, b_in, b_out;
  logic [1:0]  a_oe, b_oe;
  logic [1:0]  ab_oe_n, ab_le, ab_cap, ba_oe_n, ba_le, ba_cap;
  logic [17:0] tst_a_out, tst_b_out;
  logic [1:0]  tst_a_oe, tst_b_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bus_xcvr18 i_bus_xcvr18 (.*);

  typedef struct packed {
    logic        wide;
    logic [1:0]  oe_n;
    logic [1:0]  le;
    logic [1:0]  cap;
    logic [17:0] din;
    logic [17:0] exp_q;
    logic [1:0]  exp_oe;
  } vec_t;

  // A-to-B vectors applied in order, starting from a cleared store
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b00, 2'b11, 2'b00, 18'h3FFFF, 18'h3FFFF, 2'b11}, // R2
    '{1'b0, 2'b00, 2'b11, 2'b00, 18'h12345, 18'h12345, 2'b11}, // R2
    '{1'b0, 2'b00, 2'b00, 2'b00, 18'h0ABCD, 18'h12345, 2'b11}, // R3
    '{1'b0, 2'b10, 2'b00, 2'b01, 18'h2A5A5, 18'h123A5, 2'b01}, // R4 R7 R5
    '{1'b0, 2'b01, 2'b10, 2'b00, 18'h00FFF, 18'h00FA5, 2'b10}, // R7 R5
    '{1'b1, 2'b10, 2'b10, 2'b01, 18'h3C3C3, 18'h3C3C3, 2'b11}, // R8
    '{1'b1, 2'b01, 2'b01, 2'b00, 18'h15555, 18'h15555, 2'b00}, // R8
    '{1'b1, 2'b00, 2'b00, 2'b10, 18'h0F0F0, 18'h15555, 2'b11}  // R8 R3
  };

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; test_mode = 1'b0; wide_mode = 1'b0;
    a_in = '0; b_in = '0;
    ab_oe_n = 2'b11; ab_le = 2'b00; ab_cap = 2'b00;
    ba_oe_n = 2'b11; ba_le = 2'b00; ba_cap = 2'b00;
    tst_a_out = '0; tst_b_out = '0; tst_a_oe = '0; tst_b_oe = '0;
    @(negedge clk);
    step();
    // R1: outputs cleared under reset
    chk("R1 b_out", b_out, '0);
    chk("R1 a_out", a_out, '0);
    chk("R1 b_oe", {16'b0, b_oe}, '0);
    chk("R1 a_oe", {16'b0, a_oe}, '0);
    rst = 1'b0;

    // Table walk: A-to-B vectors, B-to-A idle and disabled (R6)
    for (int i = 0; i < NV; i++) begin
      wide_mode = VEC[i].wide;
      ab_oe_n   = VEC[i].oe_n;
      ab_le     = VEC[i].le;
      ab_cap    = VEC[i].cap;
      a_in      = VEC[i].din;
      b_in      = ~VEC[i].din;
      step();
      chk($sformatf("R2/R3/R4/R7/R8 vec%0d b_out", i), b_out, VEC[i].exp_q);
      chk($sformatf("R5 vec%0d b_oe", i), {16'b0, b_oe}, {16'b0, VEC[i].exp_oe});
      chk($sformatf("R6 vec%0d a_out", i), a_out, '0);
      chk($sformatf("R6 vec%0d a_oe", i), {16'b0, a_oe}, '0);
    end

    // R6: B-to-A transparent while A-to-B holds
    wide_mode = 1'b0;
    ab_le = 2'b00; ab_cap = 2'b00; ab_oe_n = 2'b00;
    ba_le = 2'b11; ba_oe_n = 2'b00;
    b_in = 18'h2468A; a_in = 18'h3FFFF;
    step();
    chk("R6 a_out follows b_in", a_out, 18'h2468A);
    chk("R6 a_oe", {16'b0, a_oe}, 18'h3);
    chk("R6 b_out untouched", b_out, 18'h15555);

    // R9: test mode drives outputs from test inputs; storage frozen (R10)
    test_mode = 1'b1;
    ab_le = 2'b11; ba_le = 2'b11;
    a_in = 18'h00000; b_in = 18'h3FFFF;
    tst_b_out = 18'h3FFFF; tst_b_oe = 2'b01;
    tst_a_out = 18'h11111; tst_a_oe = 2'b10;
    step();
    chk("R9 b_out", b_out, 18'h3FFFF);
    chk("R9 b_oe", {16'b0, b_oe}, 18'h1);
    chk("R9 a_out", a_out, 18'h11111);
    chk("R9 a_oe", {16'b0, a_oe}, 18'h2);

    // R10: leave test mode holding; pre-test values reappear
    test_mode = 1'b0;
    ab_le = 2'b00; ba_le = 2'b00;
    step();
    chk("R10 b_out restored", b_out, 18'h15555);
    chk("R10 a_out restored", a_out, 18'h2468A);
    chk("R10 b_oe restored", {16'b0, b_oe}, 18'h3);

    // R1: mid-run reset clears outputs and storage
    rst = 1'b1;
    step();
    chk("R1 mid b_out", b_out, '0);
    chk("R1 mid a_out", a_out, '0);
    chk("R1 mid b_oe", {16'b0, b_oe}, '0);
    rst = 1'b0;
    a_in = 18'h2AAAA;
    step();
    chk("R1 store cleared, R3 hold ignores a_in", b_out, '0);

    // R4: strobe on half 1 only, split mode
    ab_cap = 2'b10;
    step();
    chk("R4 R7 half1 capture", b_out, 18'h2AA00);
    ab_cap = 2'b00;
    a_in = 18'h00000;
    step();
    chk("R3 hold after capture", b_out, 18'h2AA00);

    done = 1'b1;
    finish_run();
  end
endmodule